// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date in packed BCD counters. A prescaler divides a slow reference tick (nominally 32768 pulses per second, presented as a one-cycle enable on the system clock) down to one pulse per second. Each second advances seconds, minutes, hours, weekday, day of month, month and a two-digit year, with a leap flag that decides the length of February. Year code 00 stands for 1970, so code 99 stands for 2069.

Software never writes the running counters directly. It fills a set of shadow registers in any order, then writes the commit register with bit 15 set. One cycle later all shadow fields move into the live counters together and the prescaler restarts from zero, so the first second after a commit is a full second. A read returns the live counters. A control bit selects 24-hour counting or a 12-hour count with a PM flag.

The commit sequencer has three states. SH_IDLE means no field has been staged since the last commit. A field write moves it to SH_STAGED. A commit write moves SH_IDLE or SH_STAGED to SH_APPLY. SH_APPLY lasts one cycle and drives the load. From SH_APPLY, another commit write keeps it in SH_APPLY, a field write moves it to SH_STAGED, and anything else returns it to SH_IDLE.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, reads return seconds 00, minutes 00, hours 00, weekday 0, day 01, month 01 and year 00 with the leap flag clear. The control register reads 1, meaning 24-hour mode.
- R2: The seconds field advances by one exactly on the 2^PRE_W-th tick_in pulse after reset or after a commit, and again every 2^PRE_W pulses after that. The default PRE_W is 15. Cycles without a tick_in pulse do not count.
- R3: Every field counts in packed BCD, with the tens digit in the upper nibble, so x9 is followed by (x+1)0. Seconds and minutes wrap from 59 to 00 and carry into the next field. In 24-hour mode, hours wrap from 23 to 00 and carry into the day.
- R4: With control bit 0 clear (12-hour mode), hour bits 4:0 count BCD 00 to 11 and hour bit 5 is a PM flag. Going from 11 AM gives PM 00 (code 0x20) and leaves the day unchanged. Going from 11 PM (code 0x31) gives AM 00 (code 0x00) and advances the day.
- R5: The day of month wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, after 30 in months 04, 06, 09 and 11, and in month 02 after 29 when the leap flag is set or after 28 when it is clear. Each wrap advances the month.
- R6: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00. Whenever the year advances, the leap flag is set exactly when 1970 plus the year is divisible by 4.
- R7: The weekday counts 0 to 6, advances once at each day wrap, and goes from 6 back to 0.
- R8: Field writes change only the shadow copies, so the live counters keep running unchanged. A write to address 7 with data bit 15 set copies every shadow field into the live counters at the next clock edge after the write is sampled, and clears the prescaler at that same edge.
- R9: Address 7 always reads as 0. A write to address 7 with bit 15 clear causes no load.
- R10: Register map, 16-bit data:
  - address 0: seconds, bits 6:0
  - address 1: minutes, bits 6:0
  - address 2: hours, bits 5:0
  - address 3: weekday, bits 2:0
  - address 4: day, bits 5:0
  - address 5: month, bits 4:0
  - address 6: year in bits 7:0 and the leap flag in bit 15
  - address 8: control, bit 0 = 24-hour mode, which takes effect immediately
  
  Write bits outside a field are dropped, and reads return zero in them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-cycle pulse per reference period (nominally 32768 Hz) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address (combinational read) |
| rd_data | output | 16 | Read data |

## Verification
The hardest conditions to reach from the ports are the long-period carries: a leap or non-leap end of February, the end of a 30-day month, the year wrap from 99 (with its leap recomputation) and the PM-to-AM midnight in 12-hour mode. Each of these needs days or years of seconds. The bench builds the design with a 3-bit prescaler and uses the commit path to place the counters one second before each boundary, then supplies exactly the number of ticks that ends one tick short of the boundary or just crosses it. A long stretch with irregular tick gaps, started just before a year end, runs against the behavioural model on every cycle.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HR_W   = 6;
    localparam int WD_W   = 3;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int YR_W   = 8;
    localparam int REG_W  = 16;
    localparam int ADR_W  = 4;
    localparam int FLAG_BIT = REG_W - 1;

    localparam logic [ADR_W-1:0] A_SEC  = 4'd0;
    localparam logic [ADR_W-1:0] A_MIN  = 4'd1;
    localparam logic [ADR_W-1:0] A_HR   = 4'd2;
    localparam logic [ADR_W-1:0] A_WD   = 4'd3;
    localparam logic [ADR_W-1:0] A_DAY  = 4'd4;
    localparam logic [ADR_W-1:0] A_MON  = 4'd5;
    localparam logic [ADR_W-1:0] A_YR   = 4'd6;
    localparam logic [ADR_W-1:0] A_TRIG = 4'd7;
    localparam logic [ADR_W-1:0] A_CTRL = 4'd8;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hour;
        logic [WD_W-1:0]  wday;
        logic [DAY_W-1:0] day;
        logic [MON_W-1:0] mon;
        logic [YR_W-1:0]  year;
        logic             leap;
    } cal_time_t;

    localparam cal_time_t CAL_RESET = '{
        sec: '0, min: '0, hour: '0, wday: '0,
        day: 6'h01, mon: 5'h01, year: '0, leap: 1'b0
    };

    // Two-digit packed BCD increment; the caller handles the wrap.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last valid day code of a month code.
    function automatic logic [DAY_W-1:0] last_day(input logic [MON_W-1:0] m,
                                                  input logic leap);
        case (m)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    // True when (1970 + year) is divisible by 4, year given in BCD.
    // (10*t + u + 2) mod 4 == (2*t[0] + u[1:0] + 2) mod 4.
    function automatic logic leap_of(input logic [YR_W-1:0] y);
        logic [1:0] s;
        s = {y[4], 1'b0} + y[1:0] + 2'd2;
        return (s == 2'd0);
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
    parameter int PRE_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic clr,
    output logic sec_tick
);
    localparam logic [PRE_W-1:0] LAST = '1;

    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick_in)
            cnt <= cnt + 1'b1;
    end

    assign sec_tick = tick_in && !clr && (cnt == LAST);

    AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));                                   // R8
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !clr) |=> $stable(cnt));                   // R2

endmodule

// File: rtl/cal_shadow.sv
`timescale 1ns/1ps
module cal_shadow
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output cal_time_t        staged,
    output logic             mode24,
    output logic             load
);
    typedef enum logic [1:0] {
        SH_IDLE,
        SH_STAGED,
        SH_APPLY
    } sh_state_e;

    sh_state_e state, state_d;
    logic fld_wr, trig_wr;
    logic unused_hi;

    assign fld_wr    = wr_en && (wr_addr <= A_YR);
    assign trig_wr   = wr_en && (wr_addr == A_TRIG) && wr_data[FLAG_BIT];
    assign unused_hi = ^wr_data[FLAG_BIT-1:8];

    always_comb begin
        state_d = state;
        unique case (state)
            SH_IDLE:   state_d = trig_wr ? SH_APPLY : (fld_wr ? SH_STAGED : SH_IDLE);
            SH_STAGED: state_d = trig_wr ? SH_APPLY : SH_STAGED;
            SH_APPLY:  state_d = trig_wr ? SH_APPLY : (fld_wr ? SH_STAGED : SH_IDLE);
            default:   state_d = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SH_IDLE;
        else
            state <= state_d;
    end

    always_comb begin
        load = (state == SH_APPLY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= CAL_RESET;
            mode24 <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                A_SEC:  staged.sec  <= wr_data[SEC_W-1:0];
                A_MIN:  staged.min  <= wr_data[MIN_W-1:0];
                A_HR:   staged.hour <= wr_data[HR_W-1:0];
                A_WD:   staged.wday <= wr_data[WD_W-1:0];
                A_DAY:  staged.day  <= wr_data[DAY_W-1:0];
                A_MON:  staged.mon  <= wr_data[MON_W-1:0];
                A_YR: begin
                    staged.year <= wr_data[YR_W-1:0];
                    staged.leap <= wr_data[FLAG_BIT];
                end
                A_CTRL: mode24 <= wr_data[0];
                default: ;
            endcase
        end
    end

    AST_TRIG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> load);                                      // R8
    AST_NO_STRAY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(trig_wr));                               // R9

endmodule

// File: rtl/cal_core.sv
`timescale 1ns/1ps
module cal_core
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  cal_time_t staged,
    input  logic      sec_tick,
    input  logic      mode24,
    output cal_time_t cur
);
    cal_time_t nx;
    logic c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        nx    = cur;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;

        if (cur.sec >= 7'h59) begin
            nx.sec = '0;
            c_min  = 1'b1;
        end else begin
            nx.sec = SEC_W'(bcd_inc({1'b0, cur.sec}));
        end

        if (c_min) begin
            if (cur.min >= 7'h59) begin
                nx.min = '0;
                c_hr   = 1'b1;
            end else begin
                nx.min = MIN_W'(bcd_inc({1'b0, cur.min}));
            end
        end

        if (c_hr) begin
            if (mode24) begin
                if (cur.hour >= 6'h23) begin
                    nx.hour = '0;
                    c_day   = 1'b1;
                end else begin
                    nx.hour = HR_W'(bcd_inc({2'b0, cur.hour}));
                end
            end else begin
                if (cur.hour[4:0] >= 5'h11) begin
                    nx.hour = {~cur.hour[5], 5'h00};
                    c_day   = cur.hour[5];
                end else begin
                    nx.hour = {cur.hour[5], 5'(bcd_inc({3'b0, cur.hour[4:0]}))};
                end
            end
        end

        if (c_day) begin
            nx.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
            if (cur.day >= last_day(cur.mon, cur.leap)) begin
                nx.day = 6'h01;
                c_mon  = 1'b1;
            end else begin
                nx.day = DAY_W'(bcd_inc({2'b0, cur.day}));
            end
        end

        if (c_mon) begin
            if (cur.mon >= 5'h12) begin
                nx.mon = 5'h01;
                c_yr   = 1'b1;
            end else begin
                nx.mon = MON_W'(bcd_inc({3'b0, cur.mon}));
            end
        end

        if (c_yr) begin
            nx.year = (cur.year >= 8'h99) ? '0 : bcd_inc(cur.year);
            nx.leap = leap_of(nx.year);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= CAL_RESET;
        else if (load)
            cur <= staged;
        else if (sec_tick)
            cur <= nx;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !sec_tick) |=> $stable(cur));                 // R2
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur == $past(staged)));                       // R8
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load && cur.sec == 7'h59) |=> (cur.sec == '0)); // R3

endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int PRE_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [ADR_W-1:0] rd_addr,
    output logic [REG_W-1:0] rd_data
);
    cal_time_t staged, live;
    logic      mode24, load, sec_tick;

    cal_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .staged  (staged),
        .mode24  (mode24),
        .load    (load)
    );

    cal_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_in),
        .clr      (load),
        .sec_tick (sec_tick)
    );

    cal_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .staged   (staged),
        .sec_tick (sec_tick),
        .mode24   (mode24),
        .cur      (live)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_SEC:  rd_data[SEC_W-1:0] = live.sec;
            A_MIN:  rd_data[MIN_W-1:0] = live.min;
            A_HR:   rd_data[HR_W-1:0]  = live.hour;
            A_WD:   rd_data[WD_W-1:0]  = live.wday;
            A_DAY:  rd_data[DAY_W-1:0] = live.day;
            A_MON:  rd_data[MON_W-1:0] = live.mon;
            A_YR: begin
                rd_data[YR_W-1:0] = live.year;
                rd_data[FLAG_BIT] = live.leap;
            end
            A_CTRL: rd_data[0] = mode24;
            default: ;
        endcase
    end

    AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_TRIG) |-> (rd_data == '0));               // R9

endmodule

// File: tb/tb_bcd_calendar.sv
`timescale 1ns/1ps
module tb_bcd_calendar;
    localparam int PW = 3;
    localparam int NT = 1 << PW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_calendar #(.PRE_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Reference model state: raw BCD codes, arithmetic done in binary.
    logic [6:0] m_sec, m_min, s_sec, s_min;
    logic [5:0] m_hr, m_day, s_hr, s_day;
    logic [2:0] m_wd, s_wd;
    logic [4:0] m_mon, s_mon;
    logic [7:0] m_yr, s_yr;
    bit m_leap, s_leap, m_24, m_pend, fire;
    int m_pre;

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int x);
        return {4'(x / 10), 4'(x % 10)};
    endfunction
    function automatic int dim(input int mo, input bit lp);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_second();
        int s, mi, h, d, mo, y;
        bit cm, ch, cd, cmo, cy, pm;
        cm = 0; ch = 0; cd = 0; cmo = 0; cy = 0;
        s = b2i({1'b0, m_sec}) + 1;
        if (s > 59) begin s = 0; cm = 1; end
        m_sec = 7'(i2b(s));
        if (cm) begin
            mi = b2i({1'b0, m_min}) + 1;
            if (mi > 59) begin mi = 0; ch = 1; end
            m_min = 7'(i2b(mi));
        end
        if (ch) begin
            if (m_24) begin
                h = b2i({2'b0, m_hr}) + 1;
                if (h > 23) begin h = 0; cd = 1; end
                m_hr = 6'(i2b(h));
            end else begin
                pm = m_hr[5];
                h = b2i({3'b0, m_hr[4:0]}) + 1;
                if (h > 11) begin h = 0; cd = pm; pm = !pm; end
                m_hr = {pm, 5'(i2b(h))};
            end
        end
        if (cd) begin
            m_wd = 3'((int'(m_wd) + 1) % 7);
            d = b2i({2'b0, m_day}) + 1;
            mo = b2i({3'b0, m_mon});
            if (d > dim(mo, m_leap)) begin d = 1; cmo = 1; end
            m_day = 6'(i2b(d));
        end
        if (cmo) begin
            mo = b2i({3'b0, m_mon}) + 1;
            if (mo > 12) begin mo = 1; cy = 1; end
            m_mon = 5'(i2b(mo));
        end
        if (cy) begin
            y = b2i(m_yr) + 1;
            if (y > 99) y = 0;
            m_yr = i2b(y);
            m_leap = ((1970 + y) % 4) == 0;
        end
    endtask

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_day = 6'h01; m_mon = 5'h01;
        m_yr = 0; m_leap = 0; m_24 = 1; m_pend = 0; m_pre = 0;
        s_sec = 0; s_min = 0; s_hr = 0; s_wd = 0; s_day = 6'h01; s_mon = 5'h01;
        s_yr = 0; s_leap = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            fire = wr_en && wr_addr == 4'd7 && wr_data[15];
            if (m_pend) begin
                m_sec = s_sec; m_min = s_min; m_hr = s_hr; m_wd = s_wd;
                m_day = s_day; m_mon = s_mon; m_yr = s_yr; m_leap = s_leap;
                m_pre = 0;
            end else if (tick_in) begin
                if (m_pre == NT - 1) model_second();
                m_pre = (m_pre + 1) % NT;
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: s_sec = wr_data[6:0];
                    4'd1: s_min = wr_data[6:0];
                    4'd2: s_hr  = wr_data[5:0];
                    4'd3: s_wd  = wr_data[2:0];
                    4'd4: s_day = wr_data[5:0];
                    4'd5: s_mon = wr_data[4:0];
                    4'd6: begin s_yr = wr_data[7:0]; s_leap = wr_data[15]; end
                    4'd8: m_24 = wr_data[0];
                    default: ;
                endcase
            end
            m_pend = fire;
        end
    end

    function automatic logic [15:0] exp_rd(input int a);
        case (a)
            0: return {9'b0, m_sec};
            1: return {9'b0, m_min};
            2: return {10'b0, m_hr};
            3: return {13'b0, m_wd};
            4: return {10'b0, m_day};
            5: return {11'b0, m_mon};
            6: return {m_leap, 7'b0, m_yr};
            8: return {15'b0, m_24};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R2";
            1, 2: return "R3";
            3: return "R7";
            4: return "R5";
            5, 6: return "R6";
            7: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act,
                         input logic [15:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int a = 0; a <= 8; a++) begin
            rd_addr = 4'(a);
            #0.1;
            check(tag_of(a), rd_data, exp_rd(a), $sformatf("model addr %0d", a));
        end
    endtask

    task automatic rd_chk(input int a, input logic [15:0] exp, input string tag);
        rd_addr = 4'(a);
        #0.1;
        check(tag, rd_data, exp, $sformatf("directed addr %0d", a));
    endtask

    task automatic cyc(input logic we, input logic [3:0] a, input logic [15:0] d,
                       input logic tk);
        wr_en = we; wr_addr = a; wr_data = d; tick_in = tk;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; tick_in = 1'b0;
        compare_all();
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 16'h0, tk);
    endtask

    task automatic set_time(input logic [15:0] se, input logic [15:0] mi,
                            input logic [15:0] hr, input logic [15:0] wd,
                            input logic [15:0] dy, input logic [15:0] mo,
                            input logic [15:0] yr);
        wr(4'd0, se); wr(4'd1, mi); wr(4'd2, hr); wr(4'd3, wd);
        wr(4'd4, dy); wr(4'd5, mo); wr(4'd6, yr);
        wr(4'd7, 16'h8000);
        idle(1, 1'b0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd_chk(0, 16'h0000, "R1"); rd_chk(1, 16'h0000, "R1");
        rd_chk(2, 16'h0000, "R1"); rd_chk(3, 16'h0000, "R1");
        rd_chk(4, 16'h0001, "R1"); rd_chk(5, 16'h0001, "R1");
        rd_chk(6, 16'h0000, "R1"); rd_chk(8, 16'h0001, "R1");
        compare_all();

        // R8 staging alone leaves the live counters untouched
        wr(4'd0, 16'h0058);
        idle(3, 1'b0);
        rd_chk(0, 16'h0000, "R8");
        // R9 commit register with bit 15 clear does nothing
        wr(4'd7, 16'h7FFF);
        idle(2, 1'b0);
        rd_chk(0, 16'h0000, "R9");

        // R8 commit; R3/R5/R7 leap February midnight
        set_time(16'h58, 16'h59, 16'h23, 16'h6, 16'h28, 16'h02, 16'h8002);
        rd_chk(0, 16'h0058, "R8");
        rd_chk(7, 16'h0000, "R9");
        idle(2 * NT - 1, 1'b1);
        rd_chk(0, 16'h0059, "R2");
        idle(1, 1'b1);
        rd_chk(0, 16'h0000, "R3"); rd_chk(2, 16'h0000, "R3");
        rd_chk(4, 16'h0029, "R5"); rd_chk(3, 16'h0000, "R7");

        set_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h29, 16'h02, 16'h8002);
        idle(NT, 1'b1);
        rd_chk(4, 16'h0001, "R5"); rd_chk(5, 16'h0003, "R5"); rd_chk(3, 16'h0001, "R7");

        set_time(16'h59, 16'h59, 16'h23, 16'h3, 16'h28, 16'h02, 16'h0003);
        idle(NT, 1'b1);
        rd_chk(4, 16'h0001, "R5"); rd_chk(5, 16'h0003, "R5");

        set_time(16'h59, 16'h59, 16'h23, 16'h2, 16'h30, 16'h04, 16'h0010);
        idle(NT, 1'b1);
        rd_chk(4, 16'h0001, "R5"); rd_chk(5, 16'h0005, "R5");

        // R6 year wrap and leap recomputation
        set_time(16'h59, 16'h59, 16'h23, 16'h5, 16'h31, 16'h12, 16'h0099);
        idle(NT, 1'b1);
        rd_chk(6, 16'h0000, "R6"); rd_chk(5, 16'h0001, "R6"); rd_chk(3, 16'h0006, "R7");
        set_time(16'h59, 16'h59, 16'h23, 16'h6, 16'h31, 16'h12, 16'h0001);
        idle(NT, 1'b1);
        rd_chk(6, 16'h8002, "R6"); rd_chk(3, 16'h0000, "R7");

        // R3 BCD digit carry
        set_time(16'h09, 16'h19, 16'h09, 16'h1, 16'h09, 16'h09, 16'h0009);
        idle(NT, 1'b1);
        rd_chk(0, 16'h0010, "R3");

        // R4 12-hour mode
        wr(4'd8, 16'h0000);
        rd_chk(8, 16'h0000, "R10");
        set_time(16'h59, 16'h59, 16'h11, 16'h1, 16'h05, 16'h01, 16'h0010);
        idle(NT, 1'b1);
        rd_chk(2, 16'h0020, "R4"); rd_chk(4, 16'h0005, "R4");
        set_time(16'h59, 16'h59, 16'h31, 16'h1, 16'h05, 16'h01, 16'h0010);
        idle(NT, 1'b1);
        rd_chk(2, 16'h0000, "R4"); rd_chk(4, 16'h0006, "R4"); rd_chk(3, 16'h0002, "R7");
        wr(4'd8, 16'h0001);

        // R10 bits outside each field are dropped
        wr(4'd0, 16'hFF12); wr(4'd1, 16'hAB34); wr(4'd2, 16'h8015);
        wr(4'd3, 16'hFFF3); wr(4'd4, 16'hFF14); wr(4'd5, 16'hFF07);
        wr(4'd6, 16'h7F33); wr(4'd7, 16'hFFFF);
        idle(1, 1'b0);
        rd_chk(0, 16'h0012, "R10"); rd_chk(1, 16'h0034, "R10");
        rd_chk(2, 16'h0015, "R10"); rd_chk(3, 16'h0003, "R10");
        rd_chk(4, 16'h0014, "R10"); rd_chk(5, 16'h0007, "R10");
        rd_chk(6, 16'h0033, "R10"); rd_chk(7, 16'h0000, "R9");

        // Irregular ticks across a year end, compared to the model each cycle
        set_time(16'h50, 16'h59, 16'h23, 16'h4, 16'h31, 16'h12, 16'h0098);
        for (int i = 0; i < 1500; i++) begin
            if (i == 700) wr(4'd7, 16'h8000);
            else cyc(1'b0, 4'd0, 16'h0, 1'($urandom_range(0, 3) != 0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule